// File: doc/BRIEF.md
# System Tick Countdown Timer

A memory-mapped down-counter that produces a regular tick for an operating system or a boot monitor. Software programs a reload value, chooses the counting source and enables the counter. While it runs, the counter steps down by one per count event. On the step from one to zero it marks a wrap. On the following event it starts again from the reload value. A wrap sets a sticky flag in the control register and can also send a one-cycle interrupt request.

Two count sources are available. One is the processor clock itself. The other is a slow reference tick from outside. The reference input is synchronised and edge-detected, so each rising edge gives exactly one count event. A read-only calibration word reports three things: whether a reference tick exists, whether its 10 ms count is exact, and the number of reference ticks in 10 ms. When no reference exists, the source selection is fixed to the processor clock.

Register access is a single-cycle port with a two-bit word index and separate write and read strobes. Read data is combinational from the index.

Top module: `tick_timer`

## Requirements
- R1: After reset, control, reload and current value all read zero and `irq` is low. The exception is the source bit (control bit 2), which reads 1 when the build has no reference tick.
- R2: Word index 0 is control, 1 is reload, 2 is current value and 3 is calibration. Control bit 0 enables counting, bit 1 enables interrupts, bit 2 selects the source and bit 16 is the wrap flag. Bit 16 and all other control bits ignore writes. Reload keeps only its low 24 bits, and the upper bits read zero.
- R3: With source bit 2 set and counting enabled, every clock is a count event. An event at zero loads the reload value, and any other event decrements by one. The period is therefore reload+1 clocks.
- R4: With source bit 2 clear, one count event occurs per rising edge of `ref_tick`, a few clocks after the edge. Between edges the value holds.
- R5: A write of any data to the current-value register sets the counter to zero and clears the wrap flag.
- R6: The wrap flag (control bit 16) is set by a count event that takes the counter from 1 to 0. A read of the control register clears it. If a wrap coincides with that read, the set wins.
- R7: `irq` is high for exactly one clock after each 1-to-0 step if control bit 1 is set, and it never rises otherwise.
- R8: With a reload value of zero, the counter stays at zero and produces no flag and no `irq`.
- R9: Calibration bit 31 reads 1 when no reference tick exists. Bit 30 reads the skew setting. Bits 23:0 read the build-time 10 ms tick count. Writes to this word have no effect.
- R10: When no reference tick exists, control bit 2 reads 1 whatever is written, and counting runs on every clock.
- R11: With counting disabled, the current value holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_rd | input | 1 | Read strobe (side effect: clears the wrap flag when word 0) |
| bus_word | input | 2 | Word index: 0 control, 1 reload, 2 current, 3 calibration |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the indexed word, combinational |
| ref_tick | input | 1 | Slow reference tick, asynchronous |
| irq | output | 1 | One-cycle interrupt request on wrap |

## Verification
The bench sweeps reload values from zero to six and follows the counter clock by clock against an arithmetic model. This catches a period that is off by one, a reload taken on the wrong step, and a zero reload that still wraps or raises `irq`. It times the interrupt pulse and checks that it is masked when bit 1 is clear. A stuck or doubled pulse, or one on the wrong cycle, shows up as a mismatch. The flag is checked for set-on-wrap, clear-on-read and clear-on-current-write, and the current-value write is tested with non-zero data. A design that stores that data instead of clearing is therefore caught. Reference mode is driven with slow pulses to catch double counting on one edge or counting on the level. A second build without a reference checks that the source bit stays locked at 1.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    typedef enum logic [1:0] {
        WORD_CTRL    = 2'd0,
        WORD_RELOAD  = 2'd1,
        WORD_CURRENT = 2'd2,
        WORD_CALIB   = 2'd3
    } word_sel_e;

    localparam int unsigned CTRL_EN_BIT    = 0;
    localparam int unsigned CTRL_IRQEN_BIT = 1;
    localparam int unsigned CTRL_SRC_BIT   = 2;
    localparam int unsigned CTRL_FLAG_BIT  = 16;
    localparam int unsigned CAL_NOREF_BIT  = 31;
    localparam int unsigned CAL_SKEW_BIT   = 30;
    localparam int unsigned CAL_TICKS_W    = 24;

    typedef struct packed {
        logic flag;
        logic src_cpu;
        logic irq_en;
        logic en;
    } ctrl_t;

endpackage

// File: rtl/tick_ref_sync.sv
module tick_ref_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    output logic tick_pulse
);
    localparam int unsigned SH_W = STAGES + 1;

    logic [SH_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[SH_W-2:0], ref_in};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    // rising edge of the synchronised level, one clock wide
    assign tick_pulse = sh_q[STAGES-1] & ~sh_q[STAGES];

    AST_REF_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick_pulse |=> !tick_pulse); // R4

endmodule

// File: rtl/tick_down_counter.sv
module tick_down_counter #(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_ev,
    input  logic             clear,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] value,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        wrap  = 1'b0;
        if (clear) begin
            cnt_d = '0;
        end else if (count_ev) begin
            if (cnt_q == '0) begin
                cnt_d = reload;
            end else begin
                cnt_d = cnt_q - ONE;
                wrap  = (cnt_q == ONE);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign value = cnt_q;

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_ev && !clear) |=> $stable(value)); // R11
    AST_CLEAR_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (value == '0)); // R5
    AST_ZERO_LOADS_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (count_ev && !clear && value == '0) |=> (value == $past(reload))); // R3

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int unsigned          CNT_W       = 24,
    parameter bit                   HAS_REF     = 1'b1,
    parameter bit                   SKEWED      = 1'b0,
    parameter logic [CAL_TICKS_W-1:0] CAL_TICKS = 24'd10000,
    parameter int unsigned          SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [1:0]  bus_word,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        ref_tick,
    output logic        irq
);
    localparam logic NO_REF = ~HAS_REF;

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] reload;
        logic             irq;
    } state_t;

    state_t           st_d, st_q;
    word_sel_e        sel;
    logic             ref_pulse;
    logic             count_ev;
    logic             cur_clr;
    logic             wrap;
    logic [CNT_W-1:0] cnt;
    logic             wdata_unused;

    assign sel          = word_sel_e'(bus_word);
    assign wdata_unused = ^(bus_wdata >> CNT_W);

    tick_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_in    (ref_tick),
        .tick_pulse(ref_pulse)
    );

    assign count_ev = st_q.ctrl.en & (st_q.ctrl.src_cpu | ref_pulse);
    assign cur_clr  = bus_wr & (sel == WORD_CURRENT);

    tick_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .count_ev(count_ev),
        .clear   (cur_clr),
        .reload  (st_q.reload),
        .value   (cnt),
        .wrap    (wrap)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (bus_wr && sel == WORD_CTRL) begin
            st_d.ctrl.en      = bus_wdata[CTRL_EN_BIT];
            st_d.ctrl.irq_en  = bus_wdata[CTRL_IRQEN_BIT];
            st_d.ctrl.src_cpu = bus_wdata[CTRL_SRC_BIT] | NO_REF;
        end
        if (bus_wr && sel == WORD_RELOAD) begin
            st_d.reload = bus_wdata[CNT_W-1:0];
        end
        if ((bus_rd && sel == WORD_CTRL) || cur_clr) begin
            st_d.ctrl.flag = 1'b0;
        end
        if (wrap) begin
            st_d.ctrl.flag = 1'b1;
            st_d.irq       = st_q.ctrl.irq_en;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q              <= '0;
            st_q.ctrl.src_cpu <= NO_REF;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (sel)
            WORD_CTRL: begin
                bus_rdata[CTRL_EN_BIT]    = st_q.ctrl.en;
                bus_rdata[CTRL_IRQEN_BIT] = st_q.ctrl.irq_en;
                bus_rdata[CTRL_SRC_BIT]   = st_q.ctrl.src_cpu;
                bus_rdata[CTRL_FLAG_BIT]  = st_q.ctrl.flag;
            end
            WORD_RELOAD:  bus_rdata = 32'(st_q.reload);
            WORD_CURRENT: bus_rdata = 32'(cnt);
            WORD_CALIB: begin
                bus_rdata[CAL_TICKS_W-1:0] = CAL_TICKS;
                bus_rdata[CAL_SKEW_BIT]    = SKEWED;
                bus_rdata[CAL_NOREF_BIT]   = NO_REF;
            end
            default: bus_rdata = '0;
        endcase
    end

    assign irq = st_q.irq;

    AST_IRQ_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(cnt) == CNT_W'(1) && cnt == '0)); // R7
    AST_FLAG_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> st_q.ctrl.flag); // R6
    AST_ZERO_RELOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.reload == '0 && cnt == '0 && !(bus_wr && sel == WORD_RELOAD)) |=> (!irq && cnt == '0)); // R8
    AST_SRC_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (NO_REF == 1'b1) |-> st_q.ctrl.src_cpu); // R10

endmodule

// File: tb/tb_tick_timer.sv
module tb_tick_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_wr2 = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_word = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata, rdata2;
    logic        ref_tick = 1'b0;
    logic        irq, irq2;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    tick_timer #(.CNT_W(24), .HAS_REF(1'b1), .SKEWED(1'b1),
                 .CAL_TICKS(24'h0003E8), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(rdata),
        .ref_tick(ref_tick), .irq(irq)
    );

    tick_timer #(.CNT_W(24), .HAS_REF(1'b0), .SKEWED(1'b0),
                 .CAL_TICKS(24'h000000), .SYNC_STAGES(2)) dut_noref (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr2), .bus_rd(1'b0),
        .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(rdata2),
        .ref_tick(1'b0), .irq(irq2)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic second, input logic [1:0] w, input logic [31:0] d);
        @(negedge clk);
        bus_word = w; bus_wdata = d;
        if (second) bus_wr2 = 1'b1; else bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_wr2 = 1'b0;
    endtask

    task automatic rd(input logic [1:0] w, output logic [31:0] d);
        @(negedge clk);
        bus_word = w; bus_rd = 1'b1;
        #1 d = rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic peek(input logic second, input logic [1:0] w, output logic [31:0] d);
        bus_word = w;
        #1 d = second ? rdata2 : rdata;
    endtask

    task automatic ref_edge();
        ref_tick = 1'b1;
        repeat (4) @(posedge clk);
        #1 ref_tick = 1'b0;
        repeat (4) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int unsigned v;
        logic irq_exp;
        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        peek(0, 2'd0, d); check("R1 ctrl", d, 32'h0);
        peek(0, 2'd1, d); check("R1 reload", d, 32'h0);
        peek(0, 2'd2, d); check("R1 current", d, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
        peek(1, 2'd0, d); check("R1 R10 ctrl noref", d, 32'h4);

        // R9 calibration
        peek(0, 2'd3, d); check("R9 calib", d, 32'h400003E8);
        peek(1, 2'd3, d); check("R9 calib noref", d, 32'h80000000);
        wr(0, 2'd3, 32'hFFFFFFFF);
        peek(0, 2'd3, d); check("R9 calib write ignored", d, 32'h400003E8);

        // R2 register fields
        wr(0, 2'd1, 32'hFFABCDEF);
        peek(0, 2'd1, d); check("R2 reload width", d, 32'h00ABCDEF);
        wr(0, 2'd0, 32'hFFFFFFFA);
        peek(0, 2'd0, d); check("R2 ctrl fields", d, 32'h00000002);
        wr(0, 2'd0, 32'h4);

        // R3 R7 R8 sweep over small reload values on the processor clock
        for (int r = 0; r <= 6; r++) begin
            logic ie;
            ie = r[0];
            wr(0, 2'd0, 32'h4);
            wr(0, 2'd1, 32'(r));
            wr(0, 2'd2, 32'h0);
            wr(0, 2'd0, 32'h5 | {30'b0, ie, 1'b0});
            bus_word = 2'd2;
            v = 0; irq_exp = 1'b0;
            for (int k = 0; k < 3 * (r + 1) + 4; k++) begin
                @(negedge clk);
                check(r == 0 ? "R8 value" : "R3 value", rdata, 32'(v));
                check(r == 0 ? "R8 irq" : "R7 irq", {31'b0, irq}, {31'b0, irq_exp});
                irq_exp = (v == 1) && ie;
                v = (v == 0) ? r : v - 1;
            end
        end
        wr(0, 2'd0, 32'h4);
        rd(2'd0, d);

        // R6 flag set on wrap, cleared by read
        wr(0, 2'd1, 32'd3);
        wr(0, 2'd2, 32'h0);
        rd(2'd0, d);
        wr(0, 2'd0, 32'h5);
        repeat (6) @(posedge clk);
        wr(0, 2'd0, 32'h4);
        rd(2'd0, d); check("R6 flag set", d, 32'h00010004);
        rd(2'd0, d); check("R6 flag cleared by read", d, 32'h4);

        // R11 hold when disabled
        peek(0, 2'd2, d); check("R11 value", d, 32'd1);
        repeat (3) @(posedge clk);
        #1 peek(0, 2'd2, d); check("R11 hold", d, 32'd1);

        // R5 current write clears value and flag
        wr(0, 2'd0, 32'h5);
        wr(0, 2'd0, 32'h5);
        wr(0, 2'd0, 32'h4);
        peek(0, 2'd2, d); check("R5 pre value", d, 32'd3);
        wr(0, 2'd2, 32'h00ABCDEF);
        peek(0, 2'd2, d); check("R5 cleared", d, 32'h0);
        rd(2'd0, d); check("R5 flag cleared", d, 32'h4);

        // R4 reference tick counting
        wr(0, 2'd1, 32'd5);
        wr(0, 2'd2, 32'h0);
        wr(0, 2'd0, 32'h1);
        bus_word = 2'd2;
        v = 0;
        for (int i = 0; i < 9; i++) begin
            ref_edge();
            v = (v == 0) ? 5 : v - 1;
            peek(0, 2'd2, d); check("R4 ref count", d, 32'(v));
        end
        repeat (10) @(posedge clk);
        #1 peek(0, 2'd2, d); check("R4 hold between edges", d, 32'(v));
        wr(0, 2'd0, 32'h0);

        // R10 no reference: source locked, counts every clock
        wr(1, 2'd0, 32'h0);
        peek(1, 2'd0, d); check("R10 source locked", d, 32'h4);
        wr(1, 2'd1, 32'd2);
        wr(1, 2'd0, 32'h1);
        bus_word = 2'd2;
        v = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            check("R10 counts on clock", rdata2, 32'(v));
            v = (v == 0) ? 2 : v - 1;
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule